// File: doc/BRIEF.md
# Selectable-Period Supervisory Watchdog

This block watches a system for signs of life. Software (or another agent) must pulse a service strobe more often than a chosen timeout. If the strobe does not arrive in time, the block drives a reset pulse of fixed length. It then starts timing again. A two-bit period selector chooses one of three timeouts. Its fourth code switches the watchdog off, and that is the state the block is in after power-up.

All time is measured in ticks of a single-cycle enable input, nominally one per millisecond. A fast tick can therefore stand in for real time. A sticky cause flag records that at least one timeout reset has happened since power-up. Supervisory logic can read it to tell a watchdog reset from a power-on reset.

Top module: `wdog_supervisor`

## Requirements
- R1: After the active-low power-on reset, `sysRstOut` and `wdogCause` are 0 and the watchdog is disabled.
- R2: With `periodSel` = 2'b00, `sysRstOut` rises on the edge that takes the LONG_TICKS-th tick (default 1400) after the count restarts, and not before.
- R3: With `periodSel` = 2'b01, the timeout is MID_TICKS ticks (default 600).
- R4: With `periodSel` = 2'b10, the timeout is SHORT_TICKS ticks (default 200).
- R5: A `kickIn` cycle while counting restarts the count from zero. A kick takes priority over a tick in the same cycle.
- R6: Any change of `periodSel` restarts the count from zero under the new selection.
- R7: The reset pulse lasts exactly HOLD_TICKS ticks (default 100). The timeout count then restarts from zero.
- R8: `wdogCause` goes to 1 on the edge where a timeout reset begins. It stays 1 until the next power-on reset.
- R9: Kicks during the reset pulse are ignored, and the pulse still lasts HOLD_TICKS ticks.
- R10: With `periodSel` = 2'b11 the watchdog is disabled. `sysRstOut` is 0 from the next edge on, which ends a pulse in progress, and no number of ticks raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| kickIn | input | 1 | Service strobe, one cycle per kick |
| periodSel | input | 2 | Timeout select: 00 long, 01 mid, 10 short, 11 disabled |
| tickEn | input | 1 | Time-base enable, one cycle per tick |
| sysRstOut | output | 1 | Active-high reset pulse on timeout |
| wdogCause | output | 1 | Sticky flag: a timeout reset has occurred since power-up |

## Verification
The bench builds the block with LONG_TICKS=14, MID_TICKS=6, SHORT_TICKS=3 and HOLD_TICKS=4. With these values every timeout and pulse boundary can be reached in a few dozen ticks. The bench drives each tick by hand, so the last silent tick and the first asserted tick can be checked for every selection. Kicks, selection changes and a switch to the disabled code are placed on exact tick counts, both in the middle of a timeout window and in the middle of a pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_COUNT = 2'd1,
    ST_PULSE = 2'd2
  } wdState_t;

  typedef struct packed {
    logic clr;
    logic inc;
  } cntCmd_t;

  localparam logic [1:0] SEL_OFF = 2'b11;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int LONG_TICKS  = 1400,
  parameter int MID_TICKS   = 600,
  parameter int SHORT_TICKS = 200,
  parameter int HOLD_TICKS  = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  cntCmd_t    cmd,
  input  logic [1:0] periodSel,
  output logic       periodDone,
  output logic       holdDone
);
  localparam int MAX_A   = (LONG_TICKS > MID_TICKS) ? LONG_TICKS : MID_TICKS;
  localparam int MAX_B   = (SHORT_TICKS > HOLD_TICKS) ? SHORT_TICKS : HOLD_TICKS;
  localparam int MAX_ALL = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);

  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_TICKS - 1);
  localparam logic [CNT_W-1:0] LAST_MID   = CNT_W'(MID_TICKS - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_TICKS - 1);
  localparam logic [CNT_W-1:0] LAST_HOLD  = CNT_W'(HOLD_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(MAX_ALL - 1);

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] lastTick;

  always_comb begin
    case (periodSel)
      2'b00:   lastTick = LAST_LONG;
      2'b01:   lastTick = LAST_MID;
      2'b10:   lastTick = LAST_SHORT;
      default: lastTick = CNT_MAX;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        tickCnt <= '0;
    else if (cmd.clr) tickCnt <= '0;
    else if (cmd.inc) tickCnt <= tickCnt + 1'b1;
  end

  assign periodDone = (tickCnt == lastTick);
  assign holdDone   = (tickCnt == LAST_HOLD);

  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clr |=> (tickCnt == '0));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= CNT_MAX);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       kickIn,
  input  logic       tickEn,
  input  logic [1:0] periodSel,
  input  logic       periodDone,
  input  logic       holdDone,
  output cntCmd_t    cmd,
  output logic       sysRst,
  output logic       causeFlag
);
  wdState_t   state, nxtState;
  logic [1:0] prevSel;
  logic       nxtRst;
  logic       setCause;
  logic       selChanged;
  logic       selOff;

  assign selChanged = (periodSel != prevSel);
  assign selOff     = (periodSel == SEL_OFF);

  always_comb begin
    nxtState = state;
    nxtRst   = sysRst;
    setCause = 1'b0;
    cmd      = '0;
    case (state)
      ST_OFF: begin
        cmd.clr = 1'b1;
        nxtRst  = 1'b0;
        if (selChanged && !selOff) nxtState = ST_COUNT;
      end
      ST_COUNT: begin
        if (selChanged) begin
          cmd.clr = 1'b1;
          if (selOff) nxtState = ST_OFF;
        end else if (kickIn) begin
          cmd.clr = 1'b1;
        end else if (tickEn) begin
          if (periodDone) begin
            nxtState = ST_PULSE;
            cmd.clr  = 1'b1;
            nxtRst   = 1'b1;
            setCause = 1'b1;
          end else begin
            cmd.inc = 1'b1;
          end
        end
      end
      ST_PULSE: begin
        if (selOff) begin
          nxtState = ST_OFF;
          cmd.clr  = 1'b1;
          nxtRst   = 1'b0;
        end else if (tickEn) begin
          if (holdDone) begin
            nxtState = ST_COUNT;
            cmd.clr  = 1'b1;
            nxtRst   = 1'b0;
          end else begin
            cmd.inc = 1'b1;
          end
        end
      end
      default: begin
        nxtState = ST_OFF;
        cmd.clr  = 1'b1;
        nxtRst   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_OFF;
      prevSel   <= SEL_OFF;
      sysRst    <= 1'b0;
      causeFlag <= 1'b0;
    end else begin
      state   <= nxtState;
      prevSel <= periodSel;
      sysRst  <= nxtRst;
      if (setCause) causeFlag <= 1'b1;
    end
  end

  // R10
  off_no_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodSel == SEL_OFF) |=> !sysRst);

  // R8
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    causeFlag |=> causeFlag);

  // R8
  cause_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRst) |-> causeFlag);

  // R2
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRst) |-> $past(tickEn));
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_pkg::*;
#(
  parameter int LONG_TICKS  = 1400,
  parameter int MID_TICKS   = 600,
  parameter int SHORT_TICKS = 200,
  parameter int HOLD_TICKS  = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       kickIn,
  input  logic [1:0] periodSel,
  input  logic       tickEn,
  output logic       sysRstOut,
  output logic       wdogCause
);
  cntCmd_t cntCmd;
  logic    periodDone;
  logic    holdDone;

  wdog_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .kickIn     (kickIn),
    .tickEn     (tickEn),
    .periodSel  (periodSel),
    .periodDone (periodDone),
    .holdDone   (holdDone),
    .cmd        (cntCmd),
    .sysRst     (sysRstOut),
    .causeFlag  (wdogCause)
  );

  wdog_datapath #(
    .LONG_TICKS  (LONG_TICKS),
    .MID_TICKS   (MID_TICKS),
    .SHORT_TICKS (SHORT_TICKS),
    .HOLD_TICKS  (HOLD_TICKS)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cntCmd),
    .periodSel  (periodSel),
    .periodDone (periodDone),
    .holdDone   (holdDone)
  );
endmodule

// File: tb/wdog_supervisor_test.sv
`timescale 1ns/1ps
module wdog_supervisor_test;
  localparam int LONG  = 14;
  localparam int MID   = 6;
  localparam int SHORT = 3;
  localparam int HOLD  = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       kickIn = 1'b0;
  logic [1:0] periodSel = 2'b11;
  logic       tickEn = 1'b0;
  logic       sysRstOut;
  logic       wdogCause;
  int         vectors = 0;
  int         fails = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  wdog_supervisor #(
    .LONG_TICKS(LONG), .MID_TICKS(MID), .SHORT_TICKS(SHORT), .HOLD_TICKS(HOLD)
  ) uut (
    .clk(clk), .rstN(rstN), .kickIn(kickIn), .periodSel(periodSel),
    .tickEn(tickEn), .sysRstOut(sysRstOut), .wdogCause(wdogCause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doTicks(input int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  task automatic setSel(input logic [1:0] s);
    periodSel = s;
    @(negedge clk);
  endtask

  task automatic kick();
    kickIn = 1'b1;
    @(negedge clk);
    kickIn = 1'b0;
  endtask

  task automatic powerUp();
    rstN = 1'b0;
    periodSel = 2'b11;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // R1, R10: reset state, then disabled under many ticks
  task automatic testResetAndOff();
    powerUp();
    chk("R1 rst after power-up", sysRstOut, 0);
    chk("R1 cause after power-up", wdogCause, 0);
    doTicks(3 * LONG);
    chk("R10 disabled stays quiet", sysRstOut, 0);
  endtask

  // R2/R3/R4 timeout, R7 pulse length and restart, R8 cause set
  task automatic testPeriod(input logic [1:0] s, input int n, input string tag);
    setSel(s);
    doTicks(n - 1);
    chk({tag, " no rst before timeout"}, sysRstOut, 0);
    doTicks(1);
    chk({tag, " rst at timeout"}, sysRstOut, 1);
    chk("R8 cause set", wdogCause, 1);
    doTicks(HOLD - 1);
    chk("R7 pulse still high", sysRstOut, 1);
    doTicks(1);
    chk("R7 pulse ended", sysRstOut, 0);
    doTicks(n - 1);
    chk("R7 restart no early rst", sysRstOut, 0);
    doTicks(1);
    chk("R7 second timeout", sysRstOut, 1);
    doTicks(HOLD);
    chk("R8 cause sticky", wdogCause, 1);
    setSel(2'b11);
  endtask

  // R5: kick restarts; kick beats tick in same cycle
  task automatic testKick();
    setSel(2'b01);
    doTicks(MID - 2);
    kick();
    doTicks(MID - 1);
    chk("R5 kicked, no rst", sysRstOut, 0);
    kickIn = 1'b1;
    tickEn = 1'b1;
    @(negedge clk);
    kickIn = 1'b0;
    tickEn = 1'b0;
    doTicks(MID - 1);
    chk("R5 kick beats tick", sysRstOut, 0);
    doTicks(1);
    chk("R5 timeout after kick", sysRstOut, 1);
    doTicks(HOLD);
    setSel(2'b11);
  endtask

  // R6: select change restarts count under new period
  task automatic testSelChange();
    setSel(2'b00);
    doTicks(LONG - 2);
    setSel(2'b01);
    doTicks(MID - 1);
    chk("R6 restart after change", sysRstOut, 0);
    doTicks(1);
    chk("R6 new period applies", sysRstOut, 1);
    doTicks(HOLD);
    setSel(2'b11);
  endtask

  // R9: kicks ignored during pulse
  task automatic testKickInPulse();
    setSel(2'b10);
    doTicks(SHORT);
    chk("R9 pulse started", sysRstOut, 1);
    doTicks(HOLD - 2);
    kick();
    doTicks(1);
    chk("R9 kick did not stretch or end", sysRstOut, 1);
    doTicks(1);
    chk("R9 pulse ends on time", sysRstOut, 0);
    setSel(2'b11);
  endtask

  // R10: disabling mid-pulse ends it
  task automatic testOffInPulse();
    setSel(2'b10);
    doTicks(SHORT);
    chk("R10 pulse started", sysRstOut, 1);
    setSel(2'b11);
    chk("R10 pulse cut by disable", sysRstOut, 0);
    doTicks(3 * LONG);
    chk("R10 disabled after cut", sysRstOut, 0);
  endtask

  // R8: cause cleared only by power-on reset
  task automatic testCauseClear();
    chk("R8 cause held before reset", wdogCause, 1);
    powerUp();
    chk("R8 cause cleared by power-up", wdogCause, 0);
    chk("R1 rst low after power-up", sysRstOut, 0);
  endtask

  initial begin
    @(negedge clk);
    testResetAndOff();
    testPeriod(2'b00, LONG, "R2");
    testPeriod(2'b01, MID, "R3");
    testPeriod(2'b10, SHORT, "R4");
    testKick();
    testSelChange();
    testKickInPulse();
    testOffInPulse();
    testCauseClear();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule